// File: doc/BRIEF.md
# Cascaded Microsecond Time Base

This block forms a microsecond time base from two chained down-counters driven by the core clock. A narrow low stage is preset to a small count. It counts down to zero and then reloads itself, so it produces one underflow every `LO_PRELOAD + 1` clocks. With the default preset of 9 on a 10 MHz-class clock, that is one underflow per microsecond. When the chaining (combine) input is set, each underflow takes one step off a wide high stage. The high stage starts at all ones and carries no interrupt. Software sees the high stage through an observation port that holds the bitwise inverse of the down-count, so the value rises from 0 by one per low-stage period.

A two-state controller, ST_IDLE and ST_RUN, sequences the counting. ST_IDLE goes to ST_RUN when `run_en` is high, and ST_RUN goes back to ST_IDLE when `run_en` is low. Counting happens only in ST_RUN, while `run_en` is high and `restart` is low. This means the first cycle after ST_IDLE is an arming cycle in which nothing counts. If `restart` and `run_en` are both high, both stages reload in the same cycle, from either state, and the controller enters ST_RUN. When the high down-count steps past zero, it returns to all ones and raises a one-cycle wrap flag.

Top module: `usec_timebase`

## Requirements
- R1: After reset, `hi_obs` is 0, and `hi_wrap` and `tick_o` are low.
- R2: A cycle with `run_en` and `restart` both high reloads both stages at that edge. `hi_obs` reads 0 on the next cycle. The first increment follows after exactly `LO_PRELOAD + 1` counting cycles.
- R3: While counting, the low stage goes from `LO_PRELOAD` down to 0 and then reloads. `tick_o` is high for one cycle, the cycle in which the low count is 0. Between restarts this repeats every `LO_PRELOAD + 1` cycles.
- R4: `hi_obs` is the bitwise inverse of the high down-count. With combine set, it rises by exactly one at the edge that ends each `tick_o` cycle, and it does not change otherwise.
- R5: While `run_en` is low, both stages hold, and `hi_obs` and the low count stay unchanged.
- R6: Raising `run_en` again without `restart` costs one arming cycle (ST_IDLE to ST_RUN). Counting then resumes from the held low count.
- R7: With `combine` low, the high stage holds, while the low stage keeps reloading and `tick_o` keeps pulsing.
- R8: When the high down-count steps from 0, it reloads to all ones. `hi_obs` returns to 0, and `hi_wrap` is high for exactly that one cycle.
- R9: `restart` while `run_en` is low has no effect on either stage.
- R10: If `restart` (with `run_en`) falls in the same cycle as a low-stage count of 0, the reload wins. No step is taken, and `hi_obs` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enable counting |
| restart | input | 1 | With run_en, reload both stages |
| combine | input | 1 | Chain low-stage underflows into the high stage |
| hi_obs | output | HI_W | Rising observation (inverse of high down-count) |
| hi_wrap | output | 1 | One-cycle pulse when the high stage wraps |
| tick_o | output | 1 | Low-stage underflow (cascade) pulse |

## Verification
Two events can land in the same cycle: a restart and a low-stage underflow. The restart would clear the stages, and the underflow would step the high stage and reload the low one. The bench counts nine cycles after a reload, confirms that `tick_o` is high, and asserts `restart` in exactly that cycle. It then checks that `hi_obs` reads 0 instead of 1, and that the next increment arrives a full ten cycles later. This shows that the reload took priority and that no cascade step was lost or doubled.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tb_state_e;

    typedef struct packed {
        logic load;
        logic count;
    } tb_cmd_t;

endpackage

// File: rtl/usec_timebase_ctrl.sv
module usec_timebase_ctrl
    import usec_timebase_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    run_en,
    input  logic    restart,
    output tb_cmd_t cmd
);

    tb_state_e state_q;
    tb_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = run_en ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = run_en ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // command outputs: reload in any state, count only once armed
    always_comb begin
        cmd.load  = run_en & restart;
        cmd.count = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd.count = 1'b0;
            ST_RUN:  cmd.count = run_en & ~restart;
            default: cmd.count = 1'b0;
        endcase
    end

endmodule

// File: rtl/usec_lo_stage.sv
module usec_lo_stage #(
    parameter int unsigned LO_W       = 24,
    parameter int unsigned LO_PRELOAD = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic count,
    output logic uflow
);

    localparam logic [LO_W-1:0] PRE = LO_W'(LO_PRELOAD);

    logic [LO_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= PRE;
        end else if (load) begin
            lo_q <= PRE;
        end else if (count) begin
            lo_q <= (lo_q == '0) ? PRE : lo_q - 1'b1;
        end
    end

    assign uflow = count & (lo_q == '0);

endmodule

// File: rtl/usec_hi_stage.sv
module usec_hi_stage #(
    parameter int unsigned HI_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    output logic [HI_W-1:0] obs,
    output logic            wrap
);

    localparam logic [HI_W-1:0] TOP = {HI_W{1'b1}};

    logic [HI_W-1:0] hi_q;
    logic            wrap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= TOP;
            wrap_q <= 1'b0;
        end else if (load) begin
            hi_q   <= TOP;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= step & (hi_q == '0);
            if (step) begin
                hi_q <= (hi_q == '0) ? TOP : hi_q - 1'b1;
            end
        end
    end

    assign obs  = ~hi_q;
    assign wrap = wrap_q;

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
    import usec_timebase_pkg::*;
#(
    parameter int unsigned LO_W       = 24,
    parameter int unsigned HI_W       = 32,
    parameter int unsigned LO_PRELOAD = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            restart,
    input  logic            combine,
    output logic [HI_W-1:0] hi_obs,
    output logic            hi_wrap,
    output logic            tick_o
);

    tb_cmd_t cmd;
    logic    uflow;

    usec_timebase_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .restart (restart),
        .cmd     (cmd)
    );

    usec_lo_stage #(
        .LO_W       (LO_W),
        .LO_PRELOAD (LO_PRELOAD)
    ) u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd.load),
        .count (cmd.count),
        .uflow (uflow)
    );

    usec_hi_stage #(
        .HI_W (HI_W)
    ) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd.load),
        .step  (uflow & combine),
        .obs   (hi_obs),
        .wrap  (hi_wrap)
    );

    assign tick_o = uflow;

endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
    parameter int unsigned HI_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            restart,
    input logic            combine,
    input logic [HI_W-1:0] hi_obs,
    input logic            hi_wrap,
    input logic            tick_o
);

    p_tick_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (run_en && !restart));

    p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && restart) |=> (hi_obs == '0));

    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en) |=> $stable(hi_obs));

    p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && combine) |=> (hi_obs == HI_W'($past(hi_obs) + 1'b1)));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_o && combine) && !(run_en && restart)) |=> $stable(hi_obs));

    p_wrap_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wrap |-> (hi_obs == '0));

    p_wrap_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wrap |=> !hi_wrap);

endmodule

bind usec_timebase usec_timebase_chk #(.HI_W(HI_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .restart (restart),
    .combine (combine),
    .hi_obs  (hi_obs),
    .hi_wrap (hi_wrap),
    .tick_o  (tick_o)
);

// File: tb/usec_timebase_tb.sv
`timescale 1ns/1ps
module usec_timebase_tb;

    localparam int unsigned TB_HI_W = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               run_en = 1'b0;
    logic               restart = 1'b0;
    logic               combine = 1'b1;
    logic [TB_HI_W-1:0] hi_obs;
    logic               hi_wrap;
    logic               tick_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usec_timebase #(
        .LO_W       (24),
        .HI_W       (TB_HI_W),
        .LO_PRELOAD (9)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .restart (restart),
        .combine (combine),
        .hi_obs  (hi_obs),
        .hi_wrap (hi_wrap),
        .tick_o  (tick_o)
    );

    task automatic advance(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_restart();
        run_en  = 1'b1;
        restart = 1'b1;
        advance(1);
        restart = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 obs", 32'(hi_obs), 0);
        check("R1 wrap", 32'(hi_wrap), 0);
        check("R1 tick", 32'(tick_o), 0);
    endtask

    task automatic t_period();
        do_restart();
        check("R2 obs after reload", 32'(hi_obs), 0);
        advance(8);
        check("R3 no tick early", 32'(tick_o), 0);
        advance(1);
        check("R3 tick at zero", 32'(tick_o), 1);
        check("R2 no step yet", 32'(hi_obs), 0);
        advance(1);
        check("R2 first step", 32'(hi_obs), 1);
        check("R3 tick one cycle", 32'(tick_o), 0);
        advance(25);
        check("R4 obs rising", 32'(hi_obs), 3);
    endtask

    task automatic t_hold();
        do_restart();
        advance(23);
        check("R4 obs before hold", 32'(hi_obs), 2);
        run_en = 1'b0;
        advance(50);
        check("R5 obs held", 32'(hi_obs), 2);
        check("R5 no tick", 32'(tick_o), 0);
        run_en = 1'b1;
        advance(7);
        check("R6 arming cycle", 32'(hi_obs), 2);
        check("R6 low count kept", 32'(tick_o), 1);
        advance(1);
        check("R6 resumed step", 32'(hi_obs), 3);
    endtask

    task automatic t_combine_off();
        int ticks;
        ticks = 0;
        do_restart();
        advance(12);
        check("R3 obs m12", 32'(hi_obs), 1);
        combine = 1'b0;
        for (int i = 0; i < 30; i++) begin
            advance(1);
            if (tick_o) ticks++;
        end
        check("R7 high held", 32'(hi_obs), 1);
        check("R7 ticks kept", 32'(ticks), 3);
        combine = 1'b1;
        advance(7);
        check("R7 obs before resume", 32'(hi_obs), 1);
        advance(1);
        check("R7 steps again", 32'(hi_obs), 2);
    endtask

    task automatic t_wrap();
        do_restart();
        advance(2559);
        check("R8 obs top", 32'(hi_obs), 255);
        check("R8 no wrap yet", 32'(hi_wrap), 0);
        advance(1);
        check("R8 obs wraps", 32'(hi_obs), 0);
        check("R8 wrap pulse", 32'(hi_wrap), 1);
        advance(1);
        check("R8 wrap single", 32'(hi_wrap), 0);
    endtask

    task automatic t_restart_ignored();
        do_restart();
        advance(25);
        check("R9 obs before", 32'(hi_obs), 2);
        run_en  = 1'b0;
        restart = 1'b1;
        advance(1);
        restart = 1'b0;
        check("R9 restart ignored", 32'(hi_obs), 2);
        run_en = 1'b1;
        advance(1);
        check("R9 state kept", 32'(hi_obs), 2);
    endtask

    task automatic t_collision();
        do_restart();
        advance(9);
        check("R10 tick present", 32'(tick_o), 1);
        restart = 1'b1;
        advance(1);
        restart = 1'b0;
        check("R10 reload wins", 32'(hi_obs), 0);
        advance(9);
        check("R10 full period", 32'(hi_obs), 0);
        advance(1);
        check("R10 next step", 32'(hi_obs), 1);
    endtask

    initial begin
        advance(3);
        rst_n = 1'b1;
        t_reset();
        advance(1);
        t_reset();
        t_period();
        t_hold();
        t_combine_off();
        t_wrap();
        t_restart_ignored();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule